// File: doc/BRIEF.md
# Serial Port Word Buffer

This block sits between a bus-facing register front end and a serial shift engine. It holds outgoing words in a transmit queue and incoming words in a receive queue. Each queue has eight 32-bit entries. It reports occupancy, full and empty for each direction. It also drives one status bit per direction that compares occupancy against a programmable level. The compare is "at or below" on the transmit side and "strictly above" on the receive side.

Receive words that arrive while the receive queue is full are thrown away, and a sticky overrun flag records the loss. Data that sits in the receive queue without being read for a set number of serial clock ticks raises a timeout flag. The next read clears that flag. In buffered mode a busy bit rises as soon as software writes a word. It falls only when the transmit queue is empty and the engine has finished shifting. One interrupt line merges the overrun, timeout and threshold events, and each event has its own enable.

The engine takes transmit words with a one-cycle take strobe and delivers receive words with a one-cycle valid strobe. The bus side uses push and pop strobes. Read data appears on the cycle after the pop.

Top module: `spi_word_buffer`

## Requirements
- R1: Each direction stores up to 8 words in first-in first-out order. The count output runs from 0 to 8, full is 1 exactly at 8 and empty is 1 exactly at 0. All counts and flags update on the clock edge that accepts the push or pop.
- R2: A push to a full transmit queue is ignored: the count stays at 8 and the word never reaches the engine. A pop of an empty receive queue returns 0 on `rx_rdata` and leaves the count at 0.
- R3: `rx_thr_sts` is 1 when the receive count is strictly greater than `rx_thresh`, and 0 otherwise.
- R4: `tx_thr_sts` is 1 when the transmit count is less than or equal to `tx_thresh`, and 0 otherwise. Out of reset it is therefore 1.
- R5: A receive word offered while the receive queue is full is dropped and sets `ovr_flag`. The flag stays set until a cycle with `ovr_clr` high, and then reads 0 on the next cycle.
- R6: A one-cycle pulse on `tx_clr` or `rx_clr` empties that queue: on the next cycle its count is 0, empty is 1 and full is 0. A clear takes priority over a push or pop in the same cycle.
- R7: While the receive queue holds data, each `sclk_tick` advances an idle counter, and the 64th tick with no read in between sets `tmo_flag`. A pop clears the flag and restarts the count. `tmo_clr` also clears the flag. Ticks do not count while the queue is empty.
- R8: With `fifo_mode` at 1, an accepted transmit push sets `busy` on the next cycle. `busy` returns to 0 once the transmit queue is empty, no take is in progress and `eng_shift_busy` is 0. The engine holds `eng_shift_busy` high from its take cycle until shifting ends. With `fifo_mode` at 0, `busy` is 0.
- R9: `irq` is a registered OR of four terms: `ovr_flag` with `ovr_ie`, `tmo_flag` with `tmo_ie`, `rx_thr_sts` with `rx_thr_ie` and `tx_thr_sts` with `tx_thr_ie`. It follows its sources one cycle later.
- R10: A pop presents the head receive word on `rx_rdata`, and a take presents the head transmit word on `eng_tx_data`. Each appears on the cycle after the strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | Buffered mode enable for the automatic busy bit |
| tx_push | input | 1 | Write one word into the transmit queue |
| tx_wdata | input | 32 | Word to transmit |
| tx_clr | input | 1 | Empty the transmit queue |
| tx_thresh | input | 3 | Transmit level for the threshold status |
| tx_count | output | 4 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_thr_sts | output | 1 | Transmit count at or below level |
| rx_pop | input | 1 | Read one word from the receive queue |
| rx_rdata | output | 32 | Word read, valid the cycle after the pop |
| rx_clr | input | 1 | Empty the receive queue |
| rx_thresh | input | 3 | Receive level for the threshold status |
| rx_count | output | 4 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_thr_sts | output | 1 | Receive count above level |
| ovr_clr | input | 1 | Clear the overrun flag |
| ovr_flag | output | 1 | Sticky receive overrun |
| tmo_clr | input | 1 | Clear the timeout flag |
| tmo_flag | output | 1 | Receive idle timeout |
| sclk_tick | input | 1 | One pulse per serial clock period |
| busy | output | 1 | Transfer in progress in buffered mode |
| ovr_ie | input | 1 | Overrun interrupt enable |
| tmo_ie | input | 1 | Timeout interrupt enable |
| rx_thr_ie | input | 1 | Receive threshold interrupt enable |
| tx_thr_ie | input | 1 | Transmit threshold interrupt enable |
| irq | output | 1 | Merged interrupt |
| eng_tx_valid | output | 1 | Transmit word available to the engine |
| eng_tx_take | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Taken word, valid the cycle after the take |
| eng_shift_busy | input | 1 | Engine is shifting a word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |

## Verification
The hardest condition to reach is the idle timeout counted against a restart. The flag must stay low after a read at 40 ticks and a further 40 ticks, then rise exactly on the 24th tick after that. The stimulus loads two receive words, sends tick pulses one per cycle, and pops one word between the two runs so the queue never empties. Overrun is reached by delivering nine engine words with no reads. The scoreboard then confirms that the ninth word is missing from the read stream.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int WORD_W_DEF    = 32;
  localparam int DEPTH_DEF     = 8;
  localparam int IDLE_TICKS_DEF = 64;

  // Interrupt sources, gathered before masking
  typedef struct packed {
    logic ovr;
    logic tmo;
    logic rx_thr;
    logic tx_thr;
  } irq_src_t;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count_nxt;
  logic             push_ok, pop_ok;

  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clr) count_nxt = '0;
    else begin
      case ({push_ok, pop_ok})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  // storage: no reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= bump(wr_ptr);
        if (pop_ok)  rd_ptr <= bump(rd_ptr);
      end
      count <= count_nxt;
      full  <= (count_nxt == CW'(DEPTH));
      empty <= (count_nxt == '0);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rd_ptr];
    else if (pop)    dout <= '0;
  end
endmodule

// File: rtl/sfq_idle_timer.sv
module sfq_idle_timer #(
  parameter int TICKS = 64,
  localparam int TW = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic q_empty,
  input  logic rd,
  input  logic tick,
  input  logic clr,
  output logic flag
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (q_empty || rd)
        cnt <= '0;
      else if (tick && cnt != TW'(TICKS))
        cnt <= cnt + 1'b1;

      if (rd || clr)
        flag <= 1'b0;
      else if (!q_empty && tick && cnt == TW'(TICKS - 1))
        flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sfq_busy_gen.sv
module sfq_busy_gen (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic push_ok,
  input  logic q_empty,
  input  logic take,
  input  logic shifting,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst || !mode)
      busy <= 1'b0;
    else if (push_ok)
      busy <= 1'b1;
    else if (q_empty && !take && !shifting)
      busy <= 1'b0;
  end
endmodule

// File: rtl/spi_word_buffer.sv
module spi_word_buffer
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = WORD_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  parameter int IDLE_TICKS = IDLE_TICKS_DEF,
  localparam int TH_W = $clog2(DEPTH),
  localparam int CW = TH_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_clr,
  input  logic [TH_W-1:0]  tx_thresh,
  output logic [CW-1:0]    tx_count,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_thr_sts,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  input  logic             rx_clr,
  input  logic [TH_W-1:0]  rx_thresh,
  output logic [CW-1:0]    rx_count,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_thr_sts,
  input  logic             ovr_clr,
  output logic             ovr_flag,
  input  logic             tmo_clr,
  output logic             tmo_flag,
  input  logic             sclk_tick,
  output logic             busy,
  input  logic             ovr_ie,
  input  logic             tmo_ie,
  input  logic             rx_thr_ie,
  input  logic             tx_thr_ie,
  output logic             irq,
  output logic             eng_tx_valid,
  input  logic             eng_tx_take,
  output logic [WIDTH-1:0] eng_tx_data,
  input  logic             eng_shift_busy,
  input  logic             eng_rx_valid,
  input  logic [WIDTH-1:0] eng_rx_data
);
  irq_src_t src, en;

  sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .din(tx_wdata),
    .pop(eng_tx_take), .dout(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(eng_rx_valid), .din(eng_rx_data),
    .pop(rx_pop), .dout(rx_rdata),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  sfq_idle_timer #(.TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst(rst), .q_empty(rx_empty), .rd(rx_pop),
    .tick(sclk_tick), .clr(tmo_clr), .flag(tmo_flag)
  );

  sfq_busy_gen u_busy (
    .clk(clk), .rst(rst), .mode(fifo_mode),
    .push_ok(tx_push && !tx_full && !tx_clr),
    .q_empty(tx_empty), .take(eng_tx_take),
    .shifting(eng_shift_busy), .busy(busy)
  );

  assign eng_tx_valid = !tx_empty;
  assign rx_thr_sts   = rx_count > CW'(rx_thresh);
  assign tx_thr_sts   = tx_count <= CW'(tx_thresh);

  // sticky overrun: set wins over clear
  always_ff @(posedge clk) begin
    if (rst)                                  ovr_flag <= 1'b0;
    else if (eng_rx_valid && rx_full && !rx_clr) ovr_flag <= 1'b1;
    else if (ovr_clr)                         ovr_flag <= 1'b0;
  end

  assign src = '{ovr: ovr_flag, tmo: tmo_flag, rx_thr: rx_thr_sts, tx_thr: tx_thr_sts};
  assign en  = '{ovr: ovr_ie, tmo: tmo_ie, rx_thr: rx_thr_ie, tx_thr: tx_thr_ie};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(src & en);
  end
endmodule

// File: rtl/spi_word_buffer_chk.sv
module spi_word_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4,
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_mode,
  input logic             tx_push,
  input logic             tx_clr,
  input logic [CW-1:0]    tx_count,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             rx_pop,
  input logic             rx_clr,
  input logic [CW-1:0]    rx_count,
  input logic             rx_full,
  input logic             rx_empty,
  input logic [WIDTH-1:0] rx_rdata,
  input logic             ovr_clr,
  input logic             ovr_flag,
  input logic             tmo_flag,
  input logic             busy,
  input logic             eng_tx_take,
  input logic             eng_shift_busy,
  input logic             eng_rx_valid
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH));

  assert_full_push_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    tx_full && tx_push && !eng_tx_take && !tx_clr |=> tx_count == CW'(DEPTH));

  assert_empty_pop_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rx_pop && rx_empty && !eng_rx_valid && !rx_clr |=> rx_rdata == '0 && rx_count == '0);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovr_flag && !ovr_clr |=> ovr_flag);

  assert_ovr_drop_R5: assert property (@(posedge clk) disable iff (rst)
    rx_full && eng_rx_valid && !rx_pop && !rx_clr |=> ovr_flag && rx_count == CW'(DEPTH));

  assert_tx_clear_R6: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> tx_empty && !tx_full && tx_count == '0);

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> rx_empty && !rx_full && rx_count == '0);

  assert_tmo_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !tmo_flag);

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_mode && tx_push && !tx_full && !tx_clr && $past(fifo_mode) |=> busy || !fifo_mode);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    busy && fifo_mode && eng_shift_busy |=> busy || !fifo_mode);

  assert_busy_off_R8: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> !busy);
endmodule

bind spi_word_buffer spi_word_buffer_chk #(.DEPTH(DEPTH), .CW(CW), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
  .tx_push(tx_push), .tx_clr(tx_clr), .tx_count(tx_count),
  .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_pop(rx_pop), .rx_clr(rx_clr), .rx_count(rx_count),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_rdata(rx_rdata),
  .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag),
  .busy(busy), .eng_tx_take(eng_tx_take),
  .eng_shift_busy(eng_shift_busy), .eng_rx_valid(eng_rx_valid)
);

// File: tb/test_spi_word_buffer.sv
`timescale 1ns/1ps
module test_spi_word_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_mode = 0, tx_push = 0, tx_clr = 0, rx_pop = 0, rx_clr = 0;
  logic [31:0] tx_wdata = '0, eng_rx_data = '0;
  logic [2:0]  tx_thresh = '0, rx_thresh = '0;
  logic        ovr_clr = 0, tmo_clr = 0, sclk_tick = 0;
  logic        ovr_ie = 0, tmo_ie = 0, rx_thr_ie = 0, tx_thr_ie = 0;
  logic        eng_tx_take = 0, eng_shift_busy = 0, eng_rx_valid = 0;
  logic [3:0]  tx_count, rx_count;
  logic        tx_full, tx_empty, tx_thr_sts, rx_full, rx_empty, rx_thr_sts;
  logic        ovr_flag, tmo_flag, busy, irq, eng_tx_valid;
  logic [31:0] rx_rdata, eng_tx_data;

  spi_word_buffer i_spi_word_buffer (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_clr(tx_clr), .tx_thresh(tx_thresh),
    .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .tx_thr_sts(tx_thr_sts),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_clr(rx_clr), .rx_thresh(rx_thresh),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty), .rx_thr_sts(rx_thr_sts),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
    .sclk_tick(sclk_tick), .busy(busy),
    .ovr_ie(ovr_ie), .tmo_ie(tmo_ie), .rx_thr_ie(rx_thr_ie), .tx_thr_ie(tx_thr_ie), .irq(irq),
    .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take), .eng_tx_data(eng_tx_data),
    .eng_shift_busy(eng_shift_busy), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int tx_n = 0, rx_n = 0;
  logic [31:0] txq[$], rxq[$];
  logic tx_pend = 0, rx_pend = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // monitor: compare data one cycle after each take/pop against the scoreboard
  always @(negedge clk) begin
    logic [31:0] e;
    if (tx_pend) begin
      e = (txq.size() > 0) ? txq.pop_front() : 32'h0;
      check("R10 engine word order", eng_tx_data, e);
    end
    if (rx_pend) begin
      e = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
      check("R10 read word order", rx_rdata, e);
    end
    tx_pend = eng_tx_take;
    rx_pend = rx_pop;
  end

  task automatic push_tx(input logic [31:0] d);
    tx_push = 1; tx_wdata = d;
    if (tx_n < 8) begin txq.push_back(d); tx_n++; end
    cyc(); tx_push = 0;
  endtask

  task automatic take_tx();
    eng_tx_take = 1; eng_shift_busy = 1;
    cyc(); eng_tx_take = 0;
    if (tx_n > 0) tx_n--;
  endtask

  task automatic eng_rx(input logic [31:0] d);
    eng_rx_valid = 1; eng_rx_data = d;
    if (rx_n < 8) begin rxq.push_back(d); rx_n++; end
    cyc(); eng_rx_valid = 0;
  endtask

  task automatic pop_rx();
    rx_pop = 1; cyc(); rx_pop = 0;
    if (rx_n > 0) rx_n--;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin sclk_tick = 1; cyc(); sclk_tick = 0; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 0; cyc();
    // reset state
    check("R1 reset tx_count", tx_count, 0);
    check("R1 reset rx_count", rx_count, 0);
    check("R1 reset empties", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    check("R4 reset tx_thr_sts", tx_thr_sts, 1);
    check("R3 reset rx_thr_sts", rx_thr_sts, 0);
    check("R9 reset flags/irq", {ovr_flag, tmo_flag, busy, irq}, 0);

    // transmit fill
    fifo_mode = 1; tx_thresh = 3;
    push_tx(32'hA000_0000);
    check("R8 busy after first push", busy, 1);
    for (int i = 1; i < 8; i++) push_tx(32'hA000_0000 + i);
    check("R1 tx full count", tx_count, 8);
    check("R1 tx_full", tx_full, 1);
    check("R4 tx_thr_sts at 8", tx_thr_sts, 0);
    push_tx(32'hDEAD_BEEF);
    check("R2 push to full ignored", tx_count, 8);

    // drain through the engine
    for (int i = 0; i < 4; i++) take_tx();
    check("R4 tx_thr_sts at 4", tx_thr_sts, 0);
    take_tx();
    check("R4 tx_thr_sts at 3", tx_thr_sts, 1);
    for (int i = 0; i < 3; i++) take_tx();
    check("R1 tx empty after drain", tx_empty, 1);
    check("R8 busy held while shifting", busy, 1);
    eng_shift_busy = 0; cyc();
    check("R8 busy clears", busy, 0);
    check("R2 dropped word not sent", txq.size(), 0);

    tx_thr_ie = 1; cyc(); cyc();
    check("R9 irq from tx threshold", irq, 1);
    tx_thr_ie = 0; cyc(); cyc();
    check("R9 irq masked", irq, 0);

    // mode off and transmit clear
    fifo_mode = 0;
    push_tx(32'h1111_0001);
    push_tx(32'h1111_0002);
    check("R8 busy stays 0 with mode off", busy, 0);
    tx_clr = 1; tx_push = 1; tx_wdata = 32'h2222_2222; cyc(); tx_clr = 0; tx_push = 0;
    txq.delete(); tx_n = 0;
    check("R6 tx clear count", tx_count, 0);
    check("R6 tx clear empty", {tx_empty, tx_full}, 2'b10);

    // receive threshold
    rx_thresh = 2;
    eng_rx(32'hB000_0001);
    eng_rx(32'hB000_0002);
    check("R3 rx_thr_sts at 2", rx_thr_sts, 0);
    eng_rx(32'hB000_0003);
    check("R3 rx_thr_sts at 3", rx_thr_sts, 1);
    for (int i = 0; i < 3; i++) pop_rx();
    cyc();
    check("R1 rx empty after reads", rx_empty, 1);
    pop_rx(); cyc();
    check("R2 empty pop count", rx_count, 0);
    check("R2 empty pop data", rx_rdata, 0);

    // overrun
    for (int i = 0; i < 9; i++) eng_rx(32'hC000_0000 + i);
    check("R5 rx count stays 8", rx_count, 8);
    check("R1 rx_full", rx_full, 1);
    check("R5 overrun set", ovr_flag, 1);
    ovr_ie = 1; cyc(); cyc();
    check("R9 irq from overrun", irq, 1);
    ovr_ie = 0; cyc();
    check("R5 overrun sticky", ovr_flag, 1);
    ovr_clr = 1; cyc(); ovr_clr = 0;
    check("R5 overrun cleared", ovr_flag, 0);
    for (int i = 0; i < 8; i++) pop_rx();
    cyc();
    check("R5 ninth word dropped", rxq.size(), 0);

    // receive clear
    eng_rx(32'hD000_0001);
    eng_rx(32'hD000_0002);
    rx_clr = 1; cyc(); rx_clr = 0;
    rxq.delete(); rx_n = 0;
    check("R6 rx clear count", rx_count, 0);
    check("R6 rx clear empty", rx_empty, 1);

    // idle timeout
    eng_rx(32'hE000_0001);
    ticks(63);
    check("R7 no timeout at 63", tmo_flag, 0);
    ticks(1);
    check("R7 timeout at 64", tmo_flag, 1);
    tmo_ie = 1; cyc(); cyc();
    check("R9 irq from timeout", irq, 1);
    tmo_ie = 0;
    pop_rx();
    check("R7 read clears timeout", tmo_flag, 0);
    cyc();
    ticks(70);
    check("R7 no count while empty", tmo_flag, 0);
    eng_rx(32'hE000_0002);
    eng_rx(32'hE000_0003);
    ticks(40);
    pop_rx();
    ticks(40);
    check("R7 read restarts count", tmo_flag, 0);
    ticks(24);
    check("R7 timeout after restart", tmo_flag, 1);
    tmo_clr = 1; cyc(); tmo_clr = 0;
    check("R7 write clears timeout", tmo_flag, 0);
    pop_rx(); cyc(); cyc();
    check("R1 rx drained", rx_empty, 1);

    finish_run();
  end
endmodule